// File: doc/BRIEF.md
# Control-Space Map and Register Decoder

This block sits on the processor's data bus and claims the accesses made in the dedicated control address space, which the function code marks with the value 3. The top address nibble chooses the target: the page map, the segment map, or one of a small set of local system registers. Map accesses leave the block as write strobes, byte lanes and an entry index. The index is taken from the middle address bits, and for the segment map it is paired with the current context. Read data from the map storage outside the block is steered back onto the bus.

Five registers live in the block. The 3-bit context register selects the active address space. The system enable and user DMA enable registers are 8 bits each. The bus-error cause register latches a code whenever a fault is signalled and clears itself when read. The diagnostic LED register drives lamps that light on a 0. The identification PROM slot and the serial bypass slot are stubs.

Every access is answered in the cycle in which it is presented. Register updates take effect at the following clock edge.

Top module: `ctl_space_decoder`

## Requirements
- R1: An access with a function code other than 3 gets no ack, no error and no write strobe, and it changes no register.
- R2: Address bits [31:28] select the target: 1 for the page map and 2 for the segment map. A map read returns the page-map data (32 bits) or the segment-map data (8 bits, in bits [7:0]).
- R3: `map_idx_o` carries address bits [27:13], and `map_ctx_o` carries the current context.
- R4: On a map access `map_be_o` equals `be_i`, and it is 0 otherwise. The segment-map entry and every local register sit in byte lane 0 (data bits [7:0]) and are written only when `be_i[0]` is 1.
- R5: The context register (nibble 3) stores only the low 3 bits of a write. Writing 0xFD reads back 5 in bits [2:0], and bits [7:3] of a read are don't-care.
- R6: The LED register (nibble 7) holds 8 bits that drive `led_o`, where a 0 bit means the lamp is lit.
- R7: The system enable register (nibble 4) and the user DMA enable register (nibble 5) are 8-bit registers that read back what was written. They drive `sysen_o` and `udma_en_o`.
- R8: The bus-error register (nibble 6) latches `fault_code_i` on the edge where `fault_i` is 1. A read returns the held value and clears it. A fault in the same cycle as the read takes priority, so it is kept. Writes to nibble 6 have no effect.
- R9: A control-space access made with `super_i` at 0, or made to a nibble from 8 to 14, gets an error and no ack. It raises no strobe, changes no register and reads 0.
- R10: After reset every register is 0 except the LED register, which is 0xFF with all lamps dark.
- R11: Nibble 0 (ID PROM) and nibble 15 (serial bypass) acknowledge, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Access presented this cycle |
| fc_i | input | 3 | Function code of the access |
| super_i | input | 1 | 1 when the processor is in supervisor mode |
| addr_i | input | 32 | Access address |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| be_i | input | 4 | Byte enables, where bit 0 is data bits [7:0] |
| wdata_i | input | 32 | Write data |
| fault_i | input | 1 | Fault indication for the bus-error register |
| fault_code_i | input | 8 | Cause code latched on a fault |
| pmap_rdata_i | input | 32 | Page-map entry read data |
| smap_rdata_i | input | 8 | Segment-map entry read data |
| ack_o | output | 1 | Access accepted |
| err_o | output | 1 | Access refused |
| rdata_o | output | 32 | Read data |
| pmap_we_o | output | 1 | Page-map write strobe |
| smap_we_o | output | 1 | Segment-map write strobe |
| map_be_o | output | 4 | Byte lanes for the map access |
| map_idx_o | output | 15 | Map entry index |
| map_ctx_o | output | 3 | Current context |
| sysen_o | output | 8 | System enable register |
| udma_en_o | output | 8 | User DMA enable register |
| led_o | output | 8 | Diagnostic lamps, active low |

## Verification
The assertions check four things on every cycle: foreign function codes stay silent, a refused access changes no register and raises no strobe, the context register keeps the low bits of a write, and the bus-error register follows latch-then-clear, with a fault winning over a clearing read. The bench scenarios cover the rest. These include the readback values of each register, the steering of map data, the index and byte lanes leaving on map strobes, and the behaviour of the stub slots. The bench also shows that a write with lane 0 disabled leaves a register untouched.

// File: rtl/ctl_space_decoder.sv
module ctl_space_decoder #(
  parameter int          CTX_W  = 3,
  parameter int          IDX_W  = 15,
  parameter logic [2:0]  CTL_FC = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        fc_i,
  input  logic              super_i,
  input  logic [31:0]       addr_i,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic              fault_i,
  input  logic [7:0]        fault_code_i,
  input  logic [31:0]       pmap_rdata_i,
  input  logic [7:0]        smap_rdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              pmap_we_o,
  output logic              smap_we_o,
  output logic [3:0]        map_be_o,
  output logic [IDX_W-1:0]  map_idx_o,
  output logic [CTX_W-1:0]  map_ctx_o,
  output logic [7:0]        sysen_o,
  output logic [7:0]        udma_en_o,
  output logic [7:0]        led_o
);
  localparam int IDX_LO = 13;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [3:0]       nib;
  logic             sel, bad_nib, wr_ok, lane0_wr, map_hit, rd_clr;
  logic [CTX_W-1:0] ctx_q;
  logic [7:0]       sysen_q, udma_q, berr_q, led_q;
  logic             unused_bits;

  assign nib      = addr_i[31:28];
  assign sel      = valid_i && (fc_i == CTL_FC);
  assign bad_nib  = (nib >= 4'h8) && (nib <= 4'hE);
  assign err_o    = sel && (!super_i || bad_nib);
  assign ack_o    = sel && !err_o;
  assign wr_ok    = ack_o && wr_i;
  assign lane0_wr = wr_ok && be_i[0];
  assign map_hit  = ack_o && (nib == 4'h1 || nib == 4'h2);
  assign rd_clr   = ack_o && !wr_i && (nib == 4'h6);

  assign pmap_we_o = wr_ok && (nib == 4'h1) && (|be_i);
  assign smap_we_o = lane0_wr && (nib == 4'h2);
  assign map_be_o  = map_hit ? be_i : 4'h0;
  assign map_idx_o = addr_i[IDX_HI:IDX_LO];
  assign map_ctx_o = ctx_q;
  assign sysen_o   = sysen_q;
  assign udma_en_o = udma_q;
  assign led_o     = led_q;

  assign unused_bits = ^{addr_i[IDX_LO-1:0], wdata_i[31:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= '0;
      sysen_q <= '0;
      udma_q  <= '0;
      berr_q  <= '0;
      led_q   <= '1;
    end else begin
      if (lane0_wr) begin
        case (nib)
          4'h3: ctx_q   <= wdata_i[CTX_W-1:0];
          4'h4: sysen_q <= wdata_i[7:0];
          4'h5: udma_q  <= wdata_i[7:0];
          4'h7: led_q   <= wdata_i[7:0];
          default: ;
        endcase
      end
      if (fault_i)     berr_q <= fault_code_i;
      else if (rd_clr) berr_q <= '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ack_o && !wr_i) begin
      case (nib)
        4'h1: rdata_o = pmap_rdata_i;
        4'h2: rdata_o = {24'h0, smap_rdata_i};
        4'h3: rdata_o = {{(32-CTX_W){1'b0}}, ctx_q};
        4'h4: rdata_o = {24'h0, sysen_q};
        4'h5: rdata_o = {24'h0, udma_q};
        4'h6: rdata_o = {24'h0, berr_q};
        4'h7: rdata_o = {24'h0, led_q};
        default: rdata_o = '0;
      endcase
    end
  end

  // R1
  a_r1_foreign_fc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fc_i != CTL_FC) |-> (!ack_o && !err_o && !pmap_we_o && !smap_we_o));

  // R9
  a_r9_refused_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!pmap_we_o && !smap_we_o && rdata_o == 32'h0));

  // R9
  a_r9_refused_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !fault_i) |=> ($stable(ctx_q) && $stable(sysen_q) && $stable(udma_q)
                             && $stable(led_q) && $stable(berr_q)));

  // R5
  a_r5_ctx_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && wr_i && be_i[0] && nib == 4'h3) |=> (ctx_q == $past(wdata_i[CTX_W-1:0])));

  // R8
  a_r8_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (berr_q == $past(fault_code_i)));

  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !fault_i) |=> (berr_q == 8'h0));
endmodule

// File: tb/test_ctl_space_decoder.sv
`timescale 1ns/1ps
module test_ctl_space_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  fc_i = 3'd0;
  logic        super_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic        fault_i = 1'b0;
  logic [7:0]  fault_code_i = '0;
  logic [31:0] pmap_rdata_i = 32'h1234_5678;
  logic [7:0]  smap_rdata_i = 8'hA5;
  logic        ack_o, err_o, pmap_we_o, smap_we_o;
  logic [31:0] rdata_o;
  logic [3:0]  map_be_o;
  logic [14:0] map_idx_o;
  logic [2:0]  map_ctx_o;
  logic [7:0]  sysen_o, udma_en_o, led_o;

  ctl_space_decoder i_ctl_space_decoder (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fc_i(fc_i), .super_i(super_i),
    .addr_i(addr_i), .wr_i(wr_i), .be_i(be_i), .wdata_i(wdata_i),
    .fault_i(fault_i), .fault_code_i(fault_code_i),
    .pmap_rdata_i(pmap_rdata_i), .smap_rdata_i(smap_rdata_i),
    .ack_o(ack_o), .err_o(err_o), .rdata_o(rdata_o),
    .pmap_we_o(pmap_we_o), .smap_we_o(smap_we_o), .map_be_o(map_be_o),
    .map_idx_o(map_idx_o), .map_ctx_o(map_ctx_o),
    .sysen_o(sysen_o), .udma_en_o(udma_en_o), .led_o(led_o));

  always #2 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic        c_ack, c_err, c_pwe, c_swe;
  logic [31:0] c_rd;
  logic [3:0]  c_be;
  logic [14:0] c_idx;
  logic [2:0]  c_ctx;

  typedef struct packed {
    logic [2:0]  fc;
    logic        sup;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] addr;
    logic [7:0]  wd;
    logic        ack;
    logic        err;
    logic [31:0] rd;
    logic [31:0] msk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{3'd3,1'b1,1'b0,4'h1,32'h3000_0000,8'h00,1'b1,1'b0,32'h0,        32'h7,       4'd10}, // R10 ctx reset
    '{3'd3,1'b1,1'b1,4'h1,32'h3000_0000,8'hFD,1'b1,1'b0,32'h0,        32'h0,       4'd5},
    '{3'd3,1'b1,1'b0,4'h1,32'h3000_0000,8'h00,1'b1,1'b0,32'h5,        32'h7,       4'd5},  // R5
    '{3'd3,1'b1,1'b0,4'h1,32'h7000_0000,8'h00,1'b1,1'b0,32'hFF,       32'hFF,      4'd10}, // R10 LED dark
    '{3'd3,1'b1,1'b1,4'h1,32'h7000_0000,8'hFE,1'b1,1'b0,32'h0,        32'h0,       4'd6},
    '{3'd3,1'b1,1'b0,4'h1,32'h7000_0000,8'h00,1'b1,1'b0,32'hFE,       32'hFFFFFFFF,4'd6},  // R6
    '{3'd3,1'b1,1'b1,4'h1,32'h4000_0000,8'h81,1'b1,1'b0,32'h0,        32'h0,       4'd7},
    '{3'd3,1'b1,1'b0,4'h1,32'h4000_0000,8'h00,1'b1,1'b0,32'h81,       32'hFFFFFFFF,4'd7},  // R7
    '{3'd3,1'b1,1'b1,4'h1,32'h5000_0000,8'h3C,1'b1,1'b0,32'h0,        32'h0,       4'd7},
    '{3'd3,1'b1,1'b0,4'h1,32'h5000_0000,8'h00,1'b1,1'b0,32'h3C,       32'hFFFFFFFF,4'd7},
    '{3'd5,1'b1,1'b1,4'h1,32'h3000_0000,8'h00,1'b0,1'b0,32'h0,        32'hFFFFFFFF,4'd1},  // R1
    '{3'd3,1'b1,1'b0,4'h1,32'h3000_0000,8'h00,1'b1,1'b0,32'h5,        32'h7,       4'd1},
    '{3'd3,1'b0,1'b1,4'h1,32'h3000_0000,8'h02,1'b0,1'b1,32'h0,        32'hFFFFFFFF,4'd9},  // R9 user
    '{3'd3,1'b1,1'b0,4'h1,32'h3000_0000,8'h00,1'b1,1'b0,32'h5,        32'h7,       4'd9},
    '{3'd3,1'b1,1'b0,4'h1,32'h9000_0000,8'h00,1'b0,1'b1,32'h0,        32'hFFFFFFFF,4'd9},  // R9 nibble
    '{3'd3,1'b1,1'b0,4'hF,32'h1000_0000,8'h00,1'b1,1'b0,32'h12345678, 32'hFFFFFFFF,4'd2},  // R2
    '{3'd3,1'b1,1'b0,4'h1,32'h2000_0000,8'h00,1'b1,1'b0,32'hA5,       32'hFFFFFFFF,4'd2},
    '{3'd3,1'b1,1'b0,4'hF,32'h0000_0000,8'h00,1'b1,1'b0,32'h0,        32'hFFFFFFFF,4'd11}, // R11
    '{3'd3,1'b1,1'b1,4'hF,32'hF000_0000,8'hFF,1'b1,1'b0,32'h0,        32'h0,       4'd11},
    '{3'd3,1'b1,1'b1,4'hE,32'h4000_0000,8'h00,1'b1,1'b0,32'h0,        32'h0,       4'd4},
    '{3'd3,1'b1,1'b0,4'h1,32'h4000_0000,8'h00,1'b1,1'b0,32'h81,       32'hFFFFFFFF,4'd4}   // R4
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] fc, input logic sup, input logic wr,
                     input logic [3:0] be, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    valid_i = 1'b1; fc_i = fc; super_i = sup; wr_i = wr; be_i = be;
    addr_i = addr; wdata_i = wd;
    #1;
    c_ack = ack_o; c_err = err_o; c_rd = rdata_o; c_pwe = pmap_we_o;
    c_swe = smap_we_o; c_be = map_be_o; c_idx = map_idx_o; c_ctx = map_ctx_o;
    @(posedge clk);
    #1;
    valid_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic pulse_fault(input logic [7:0] code);
    @(negedge clk);
    fault_i = 1'b1; fault_code_i = code;
    @(posedge clk);
    #1;
    fault_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: register outputs after reset
    chk(led_o == 8'hFF, "R10", {24'h0, led_o}, 32'hFF);
    chk(sysen_o == 8'h00 && udma_en_o == 8'h00, "R10", {16'h0, sysen_o, udma_en_o}, 32'h0);
    chk(map_ctx_o == 3'd0, "R10", {29'h0, map_ctx_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      acc(TBL[k].fc, TBL[k].sup, TBL[k].wr, TBL[k].be, TBL[k].addr, {24'h0, TBL[k].wd});
      chk(c_ack == TBL[k].ack && c_err == TBL[k].err, $sformatf("R%0d v%0d ack/err", TBL[k].req, k),
          {30'h0, c_ack, c_err}, {30'h0, TBL[k].ack, TBL[k].err});
      chk((c_rd & TBL[k].msk) == (TBL[k].rd & TBL[k].msk), $sformatf("R%0d v%0d rdata", TBL[k].req, k),
          c_rd & TBL[k].msk, TBL[k].rd & TBL[k].msk);
    end

    // R6: lamp output follows register (0xFE written)
    chk(led_o == 8'hFE, "R6", {24'h0, led_o}, 32'hFE);
    // R7
    chk(sysen_o == 8'h81 && udma_en_o == 8'h3C, "R7", {16'h0, sysen_o, udma_en_o}, 32'h813C);

    // R3 / R4: page-map write, index and lanes
    acc(3'd3, 1'b1, 1'b1, 4'b0110, 32'h1ABC_E000, 32'hDEAD_BEEF);
    chk(c_pwe && !c_swe, "R2", {30'h0, c_pwe, c_swe}, 32'h2);
    chk(c_be == 4'b0110, "R4", {28'h0, c_be}, 32'h6);
    chk(c_idx == 15'h55E7, "R3", {17'h0, c_idx}, 32'h55E7);
    chk(c_ctx == 3'd5, "R3", {29'h0, c_ctx}, 32'h5);

    // R4: segment map needs lane 0
    acc(3'd3, 1'b1, 1'b1, 4'b0001, 32'h2000_2000, 32'h11);
    chk(c_swe && !c_pwe, "R4", {30'h0, c_pwe, c_swe}, 32'h1);
    acc(3'd3, 1'b1, 1'b1, 4'b0010, 32'h2000_2000, 32'h11);
    chk(!c_swe && c_be == 4'b0010, "R4", {27'h0, c_swe, c_be}, 32'h2);

    // R9: user-mode map write raises no strobe
    acc(3'd3, 1'b0, 1'b1, 4'hF, 32'h1000_0000, 32'h0);
    chk(c_err && !c_pwe && c_be == 4'h0, "R9", {26'h0, c_err, c_pwe, c_be}, 32'h20);
    // R1: foreign function code map write
    acc(3'd1, 1'b1, 1'b1, 4'hF, 32'h1000_0000, 32'h0);
    chk(!c_ack && !c_err && !c_pwe, "R1", {29'h0, c_ack, c_err, c_pwe}, 32'h0);

    // R8: latch, read, clear
    pulse_fault(8'h2A);
    acc(3'd3, 1'b1, 1'b0, 4'h1, 32'h6000_0000, 32'h0);
    chk(c_rd == 32'h2A, "R8", c_rd, 32'h2A);
    acc(3'd3, 1'b1, 1'b0, 4'h1, 32'h6000_0000, 32'h0);
    chk(c_rd == 32'h0, "R8", c_rd, 32'h0);
    // R8: writes ignored
    pulse_fault(8'h17);
    acc(3'd3, 1'b1, 1'b1, 4'hF, 32'h6000_0000, 32'h99);
    acc(3'd3, 1'b1, 1'b0, 4'h1, 32'h6000_0000, 32'h0);
    chk(c_rd == 32'h17, "R8", c_rd, 32'h17);
    // R8: fault coincident with clearing read wins
    pulse_fault(8'h33);
    @(negedge clk);
    valid_i = 1'b1; fc_i = 3'd3; super_i = 1'b1; wr_i = 1'b0; be_i = 4'h1;
    addr_i = 32'h6000_0000; fault_i = 1'b1; fault_code_i = 8'h44;
    #1;
    c_rd = rdata_o;
    @(posedge clk);
    #1;
    valid_i = 1'b0; fault_i = 1'b0;
    chk(c_rd == 32'h33, "R8", c_rd, 32'h33);
    acc(3'd3, 1'b1, 1'b0, 4'h1, 32'h6000_0000, 32'h0);
    chk(c_rd == 32'h44, "R8", c_rd, 32'h44);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule